// File: doc/BRIEF.md
# Seven-Operand Carry-Save Adder Tree

This block adds seven unsigned operands of a configurable width and returns their exact total. Carries are not propagated while the operands are being combined. Rows of full-adder cells each take three vectors and return two: a sum vector and a carry vector. Each carry vector moves up one bit before it is used again. Four such levels shrink the operand count from seven to five, then four, three and two. A single ripple carry-propagate adder then merges the last two vectors into the result.

The result has three more bits than an operand, so the largest possible total (seven times the largest operand) always fits and nothing wraps. A parameter chooses between two variants. In one, the result is purely combinational. In the other, one output register holds the result and clears on an active-low asynchronous reset. The operand count is fixed at seven. Only the operand width is a parameter.

Top module: `sevenop_csa_adder`

## Requirements
- R1: For any operand values, the result equals the arithmetic sum of the seven operands, read as unsigned integers.
- R2: The result is OPW+3 bits wide. When all seven operands hold the largest value 2^OPW-1, the result is 7*(2^OPW-1), with no truncation. The result never exceeds that value.
- R3: With the output register enabled (the default), the result for the operands present at a rising clock edge appears after that edge. It holds until the next edge, even when the operands change in between.
- R4: While rst_ni is low, the registered result reads zero, whatever the operands are.
- R5: When all operands are zero, the result is zero.
- R6: All seven operand slots carry equal weight. When only one slot is nonzero, the result equals that operand, zero-extended, for every slot index 0 to 6.
- R7: A carry that crosses every operand bit position reaches the upper result bits. For example, 2^OPW-1 plus 1 gives 2^OPW, and seven copies of 2^(OPW-1) give 7*2^(OPW-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| opnd_i | input | 7*OPW | Seven unsigned operands; slot j occupies bits [j*OPW +: OPW] |
| sum_o | output | OPW+3 | Exact unsigned total of the seven operands |

## Verification
A miswired full-adder cell or a carry vector that is not shifted corrupts the result at once. With the register enabled, the error shows in the first cycle after the bad operands are sampled. It is not delayed or hidden by state, because the only state is the output register. Single-slot stimulus exposes a dropped or swapped operand in a specific slot. All-maximum operands and long-carry patterns expose a lost top carry or a result that is too narrow. Random operand sets cover mixed columns where sum and carry vectors interact at several levels.

// File: rtl/sevenop_pkg.sv
package sevenop_pkg;
   localparam int unsigned N_OPS  = 7;
   localparam int unsigned GROW_W = $clog2(N_OPS);

   function automatic int unsigned total_width(input int unsigned opw);
      return opw + GROW_W;
   endfunction
endpackage

// File: rtl/sevenop_fa_cell.sv
module sevenop_fa_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic co_o
);
   always_comb begin
      s_o  = a_i ^ b_i ^ c_i;
      co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   end
endmodule

// File: rtl/sevenop_csa_row.sv
// Three-to-two compressor row: one full-adder cell per column, carries kept
// as a separate vector and returned already moved up by one column.
module sevenop_csa_row #(
   parameter int unsigned W = 9
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cys_o
);
   logic [W-1:0] cy;

   generate
      for (genvar i = 0; i < W; i++) begin : g_col
         if (i == W - 1) begin : g_top
            // carry out of the top column would leave the result width
            assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
            assign cy[i]    = 1'b0;
         end else begin : g_fa
            sevenop_fa_cell u_fa (
               .a_i (x_i[i]),
               .b_i (y_i[i]),
               .c_i (z_i[i]),
               .s_o (sum_o[i]),
               .co_o(cy[i])
            );
         end
      end
   endgenerate

   assign cys_o = {cy[W-2:0], 1'b0};
endmodule

// File: rtl/sevenop_cpa.sv
// Final carry-propagate adder (ripple of full-adder cells).
module sevenop_cpa #(
   parameter int unsigned W = 9
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] s_o
);
   logic [W-1:0] c;

   assign c[0] = 1'b0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == W - 1) begin : g_top
            assign s_o[i] = a_i[i] ^ b_i[i] ^ c[i];
         end else begin : g_fa
            sevenop_fa_cell u_fa (
               .a_i (a_i[i]),
               .b_i (b_i[i]),
               .c_i (c[i]),
               .s_o (s_o[i]),
               .co_o(c[i+1])
            );
         end
      end
   endgenerate
endmodule

// File: rtl/sevenop_csa_adder.sv
module sevenop_csa_adder
   import sevenop_pkg::*;
#(
   parameter int unsigned OPW     = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [6:0][OPW-1:0]     opnd_i,
   output logic [OPW+2:0]          sum_o
);
   localparam int unsigned RW = total_width(OPW);

   generate
      if (OPW < 2) begin : g_chk_opw
         $error("sevenop_csa_adder: OPW must be at least 2");
      end
      if (RW != OPW + 3) begin : g_chk_rw
         $error("sevenop_csa_adder: result width must be OPW+3 for seven operands");
      end
   endgenerate

   // zero-extended operands
   logic [RW-1:0] ext [N_OPS];
   generate
      for (genvar j = 0; j < N_OPS; j++) begin : g_ext
         assign ext[j] = {{(RW-OPW){1'b0}}, opnd_i[j]};
      end
   endgenerate

   // level 1: 7 -> 5 (two rows, operand 6 passes through)
   logic [RW-1:0] l1_s [2];
   logic [RW-1:0] l1_c [2];
   generate
      for (genvar r = 0; r < 2; r++) begin : g_lvl1
         sevenop_csa_row #(.W(RW)) u_row (
            .x_i  (ext[3*r]),
            .y_i  (ext[3*r+1]),
            .z_i  (ext[3*r+2]),
            .sum_o(l1_s[r]),
            .cys_o(l1_c[r])
         );
      end
   endgenerate

   // level 2: 5 -> 4
   logic [RW-1:0] l2_s, l2_c;
   sevenop_csa_row #(.W(RW)) u_lvl2 (
      .x_i  (l1_s[0]),
      .y_i  (l1_c[0]),
      .z_i  (l1_s[1]),
      .sum_o(l2_s),
      .cys_o(l2_c)
   );

   // level 3: 4 -> 3
   logic [RW-1:0] l3_s, l3_c;
   sevenop_csa_row #(.W(RW)) u_lvl3 (
      .x_i  (l2_s),
      .y_i  (l2_c),
      .z_i  (l1_c[1]),
      .sum_o(l3_s),
      .cys_o(l3_c)
   );

   // level 4: 3 -> 2
   logic [RW-1:0] l4_s, l4_c;
   sevenop_csa_row #(.W(RW)) u_lvl4 (
      .x_i  (l3_s),
      .y_i  (l3_c),
      .z_i  (ext[6]),
      .sum_o(l4_s),
      .cys_o(l4_c)
   );

   // final carry-propagate addition
   logic [RW-1:0] total;
   sevenop_cpa #(.W(RW)) u_cpa (
      .a_i(l4_s),
      .b_i(l4_c),
      .s_o(total)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic [RW-1:0] total_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) total_q <= '0;
            else         total_q <= total;
         end
         assign sum_o = total_q;
      end else begin : g_comb
         assign sum_o = total;
      end
   endgenerate
endmodule

// File: rtl/sevenop_csa_chk.sv
module sevenop_csa_chk #(
   parameter int unsigned OPW     = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [6:0][OPW-1:0] opnd_i,
   input  logic [OPW+2:0]      sum_o
);
   localparam int unsigned RW = OPW + 3;
   localparam logic [RW-1:0] MAX_TOTAL = RW'(7 * ((1 << OPW) - 1));

   logic [RW-1:0] ref_total;
   logic [RW-1:0] lone_val;
   int unsigned   nz_cnt;

   always_comb begin
      ref_total = '0;
      lone_val  = '0;
      nz_cnt    = 0;
      for (int j = 0; j < 7; j++) begin
         ref_total = ref_total + RW'(opnd_i[j]);
         if (opnd_i[j] != '0) begin
            nz_cnt   = nz_cnt + 1;
            lone_val = RW'(opnd_i[j]);
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o <= MAX_TOTAL); // R2

   generate
      if (REG_OUT) begin : g_reg_chk
         AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rst_ni |=> sum_o == $past(ref_total)); // R1
         AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (opnd_i == '0) |=> sum_o == '0); // R5
         AST_LONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (nz_cnt == 1) |=> sum_o == $past(lone_val)); // R6
      end else begin : g_comb_chk
         AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sum_o == ref_total); // R1
         AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (opnd_i == '0) |-> sum_o == '0); // R5
         AST_LONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (nz_cnt == 1) |-> sum_o == lone_val); // R6
      end
   endgenerate
endmodule

bind sevenop_csa_adder sevenop_csa_chk #(.OPW(OPW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_sevenop_csa_adder.sv
`timescale 1ns/1ps
module tb_sevenop_csa_adder;
   localparam int K     = 6;
   localparam int RW    = K + 3;
   localparam int MAXOP = (1 << K) - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic [6:0][K-1:0] opnd;
   logic [RW-1:0]     sum;

   sevenop_csa_adder #(.OPW(K), .REG_OUT(1'b1)) dut (
      .clk_i (clk),
      .rst_ni(rst_n),
      .opnd_i(opnd),
      .sum_o (sum)
   );

   typedef struct {
      logic [RW-1:0] exp;
      string         tag;
   } item_t;
   item_t sb[$];

   int checks = 0;
   int fails  = 0;

   function automatic logic [RW-1:0] ref_sum(input logic [6:0][K-1:0] v);
      int s = 0;
      for (int j = 0; j < 7; j++) s += int'(v[j]);
      return RW'(s);
   endfunction

   task automatic check(input logic [RW-1:0] act, input logic [RW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0][K-1:0] v, input string tag);
      item_t it;
      @(negedge clk);
      opnd   = v;
      it.exp = ref_sum(v);
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: one result per clock, one register of latency
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(sum, it.exp, it.tag);
         end
      end
   end

   initial begin
      #1600000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [6:0][K-1:0] v;
      logic [6:0][K-1:0] va;
      rst_n = 1'b0;
      for (int j = 0; j < 7; j++) opnd[j] = K'(j * 9 + 5);
      repeat (3) @(negedge clk);
      check(sum, '0, "R4 reset holds zero");
      @(negedge clk);
      check(sum, '0, "R4 reset holds zero");
      rst_n = 1'b1;

      // R5 all zero
      v = '0;
      drive(v, "R5 zero operands");

      // R2 all maximum
      for (int j = 0; j < 7; j++) v[j] = K'(MAXOP);
      drive(v, "R2 all max");

      // R6 one live slot at each index
      for (int i = 0; i < 7; i++) begin
         v = '0;
         v[i] = K'(MAXOP - i);
         drive(v, "R6 lone slot");
      end

      // R7 long carries
      v = '0; v[0] = K'(MAXOP); v[1] = K'(1);
      drive(v, "R7 carry to 2^k");
      for (int j = 0; j < 7; j++) v[j] = K'(1 << (K - 1));
      drive(v, "R7 seven half-scale");
      v = '0; v[3] = K'(MAXOP); v[6] = K'(MAXOP);
      drive(v, "R7 two max");

      // R3 result holds while operands change before the next edge
      for (int j = 0; j < 7; j++) va[j] = K'(j + 1);
      drive(va, "R3 first set");
      for (int j = 0; j < 7; j++) v[j] = K'(MAXOP - j);
      drive(v, "R3 second set");
      #1;
      check(sum, ref_sum(va), "R3 held before edge");

      // R1 random operand sets
      for (int n = 0; n < 300; n++) begin
         for (int j = 0; j < 7; j++) v[j] = K'($urandom);
         drive(v, "R1 random");
      end

      repeat (4) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule